// File: doc/BRIEF.md
# Queue Doorbell Register Decoder

This block is the register slave of a paravirtual, queue-based device. It answers a simple 32-bit read/write port and does three jobs. First, it presents a read-only notification layout word, made of a 16-bit base offset and a 16-bit per-queue stride, and it watches every driver write for the doorbell addresses that this layout defines. Second, it keeps a small interrupt cause register with a write-one-to-clear acknowledge. This pair only collects events while message-signalled interrupts are switched off. Third, it offers an MSI capability word and a plain read/write device status word.

The doorbell address of queue `q` is `base + q * stride`. When the stride is zero, all queues share the single address `base`, and the written data names the queue. A base of 0x050 with a zero stride therefore turns the layout register's own address into the doorbell. Each doorbell hit produces a one-clock notify pulse together with the queue index. Read data is registered and appears one clock after the read strobe.

Top module: `qn_doorbell_regs`

## Requirements
- R1: A read of offset 0x050 returns the stride input in bits [31:16] and the base input in bits [15:0].
- R2: With a nonzero stride, a write to address `base + q*stride` for q below NUM_QUEUES raises `notify_valid` for exactly the following clock, with `notify_queue` equal to q.
- R3: With a zero stride, a write to address `base` whose full 32-bit data is below NUM_QUEUES raises `notify_valid` for the following clock, with `notify_queue` equal to the data.
- R4: A write that hits no queue's doorbell produces no notify pulse. This covers an address off the stride grid, a queue index of NUM_QUEUES or more, and a shared-address write whose data is NUM_QUEUES or more.
- R5: While `msi_enable` is low, `evt_used` sets cause bit 0 and `evt_cfg` sets cause bit 1. A read of offset 0x060 returns the cause bits in [1:0] and zero in every other bit.
- R6: A write to offset 0x064 clears each cause bit that is 1 in the written data. An event arriving in the same cycle as its bit's acknowledge leaves that bit set.
- R7: `irq` is high exactly when some cause bit is set and `msi_enable` was low at the last clock edge. While `msi_enable` is high, events set no cause bit.
- R8: A read of offset 0x0C0 returns NUM_QUEUES in bits [15:0], `msi_enable` in bit 16, and zero elsewhere.
- R9: Offset 0x070 is a 32-bit read/write word. A write to it takes effect on the next clock and is mirrored on `dev_status`.
- R10: When a write hits a doorbell, any fixed register at the same address is left unchanged: the acknowledge does not clear and the device status does not update.
- R11: Reads of unmapped offsets return zero. `bus_rdata` is zero in every cycle that follows a clock without a read. Writes to offsets 0x050, 0x060 and 0x0C0 change no state.
- R12: After reset, `notify_valid`, `irq`, `bus_rdata`, `dev_status` and the cause bits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cfg_base | input | 16 | Doorbell base offset |
| cfg_mult | input | 16 | Doorbell stride per queue |
| msi_enable | input | 1 | Message-signalled interrupts enabled |
| evt_used | input | 1 | Used-buffer event from the device |
| evt_cfg | input | 1 | Configuration-change event |
| notify_valid | output | 1 | One-clock doorbell pulse |
| notify_queue | output | QIDX_W | Queue index of the doorbell |
| irq | output | 1 | Level interrupt when MSI is off |
| dev_status | output | 32 | Device status word |

## Verification
Two things can land in the same cycle. The first is an event and the acknowledge write that clears the same cause bit. The second is a doorbell hit and a fixed register write, when the base is placed on 0x064 or 0x070 with a zero stride. Directed steps drive each of these pairs on one edge. Random traffic also places the base on those offsets while events fire. The bench model then checks, through the cause read-back, `irq`, `dev_status` and the notify outputs, that the event survived and that the doorbell won over the register.

// File: rtl/qn_pkg.sv
package qn_pkg;
  localparam logic [31:0] OFF_LAYOUT  = 32'h0000_0050;
  localparam logic [31:0] OFF_CAUSE   = 32'h0000_0060;
  localparam logic [31:0] OFF_ACK     = 32'h0000_0064;
  localparam logic [31:0] OFF_DEVSTAT = 32'h0000_0070;
  localparam logic [31:0] OFF_MSICAP  = 32'h0000_00C0;
  localparam int CAUSE_W    = 2;
  localparam int MSI_EN_BIT = 16;
endpackage

// File: rtl/qn_notify_decode.sv
module qn_notify_decode #(
  parameter int NUM_QUEUES = 8,
  parameter int QIDX_W     = 3
) (
  input  logic              wr_en,
  input  logic [31:0]       addr,
  input  logic [31:0]       wdata,
  input  logic [15:0]       base,
  input  logic [15:0]       mult,
  output logic              hit,
  output logic [QIDX_W-1:0] qidx
);
  logic [31:0]           base_w;
  logic [31:0]           mult_w;
  logic [NUM_QUEUES-1:0] slot_match;
  logic                  shared_hit;

  assign base_w = {16'h0000, base};
  assign mult_w = {16'h0000, mult};

  // one comparator per queue against its own doorbell address
  genvar g;
  generate
    for (g = 0; g < NUM_QUEUES; g++) begin : g_slot
      logic [31:0] slot_addr;
      assign slot_addr     = base_w + (mult_w * 32'(g));
      assign slot_match[g] = (mult != 16'h0000) && (addr == slot_addr);
    end
  endgenerate

  // zero stride: single shared address, queue index carried in the data
  assign shared_hit = (mult == 16'h0000) && (addr == base_w) &&
                      (wdata < 32'(NUM_QUEUES));

  always_comb begin
    hit  = 1'b0;
    qidx = '0;
    if (wr_en) begin
      if (shared_hit) begin
        hit  = 1'b1;
        qidx = wdata[QIDX_W-1:0];
      end else begin
        for (int q = NUM_QUEUES - 1; q >= 0; q--) begin
          if (slot_match[q]) begin
            hit  = 1'b1;
            qidx = QIDX_W'(q);
          end
        end
      end
    end
  end
endmodule

// File: rtl/qn_irq_cause.sv
module qn_irq_cause #(
  parameter int CAUSE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CAUSE_W-1:0] evt,
  input  logic               msi_en,
  input  logic               clr_en,
  input  logic [CAUSE_W-1:0] clr_mask,
  output logic [CAUSE_W-1:0] cause,
  output logic               irq
);
  logic [CAUSE_W-1:0] set_bits;
  logic [CAUSE_W-1:0] clr_bits;
  logic [CAUSE_W-1:0] cause_nxt;

  assign set_bits  = msi_en ? '0 : evt;
  assign clr_bits  = clr_en ? clr_mask : '0;
  // a new event outranks an acknowledge of the same bit
  assign cause_nxt = (cause & ~clr_bits) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= '0;
      irq   <= 1'b0;
    end else begin
      cause <= cause_nxt;
      irq   <= (|cause_nxt) && !msi_en;
    end
  end
endmodule

// File: rtl/qn_doorbell_regs.sv
module qn_doorbell_regs
  import qn_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_QUEUES = 8,
  parameter int QIDX_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       cfg_base,
  input  logic [15:0]       cfg_mult,
  input  logic              msi_enable,
  input  logic              evt_used,
  input  logic              evt_cfg,
  output logic              notify_valid,
  output logic [QIDX_W-1:0] notify_queue,
  output logic              irq,
  output logic [31:0]       dev_status
);
  localparam logic [15:0] QCOUNT = 16'(NUM_QUEUES);

  logic [31:0]        addr_w;
  logic               dec_hit;
  logic [QIDX_W-1:0]  dec_q;
  logic               wr_fixed;
  logic               ack_wr;
  logic [CAUSE_W-1:0] int_cause;
  logic [31:0]        rd_mux;

  assign addr_w = 32'(bus_addr);

  qn_notify_decode #(
    .NUM_QUEUES(NUM_QUEUES),
    .QIDX_W    (QIDX_W)
  ) u_decode (
    .wr_en(bus_wr),
    .addr (addr_w),
    .wdata(bus_wdata),
    .base (cfg_base),
    .mult (cfg_mult),
    .hit  (dec_hit),
    .qidx (dec_q)
  );

  // fixed registers only see writes the doorbell decode did not claim
  assign wr_fixed = bus_wr && !dec_hit;
  assign ack_wr   = wr_fixed && (addr_w == OFF_ACK);

  qn_irq_cause #(
    .CAUSE_W(CAUSE_W)
  ) u_cause (
    .clk     (clk),
    .rst     (rst),
    .evt     ({evt_cfg, evt_used}),
    .msi_en  (msi_enable),
    .clr_en  (ack_wr),
    .clr_mask(bus_wdata[CAUSE_W-1:0]),
    .cause   (int_cause),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      notify_valid <= 1'b0;
      notify_queue <= '0;
    end else begin
      notify_valid <= dec_hit;
      if (dec_hit) notify_queue <= dec_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_status <= '0;
    end else if (wr_fixed && (addr_w == OFF_DEVSTAT)) begin
      dev_status <= bus_wdata;
    end
  end

  always_comb begin
    unique case (addr_w)
      OFF_LAYOUT:  rd_mux = {cfg_mult, cfg_base};
      OFF_CAUSE:   rd_mux = {{(32-CAUSE_W){1'b0}}, int_cause};
      OFF_DEVSTAT: rd_mux = dev_status;
      OFF_MSICAP:  rd_mux = {{(31-MSI_EN_BIT){1'b0}}, msi_enable, QCOUNT};
      default:     rd_mux = 32'h0000_0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_mux : 32'h0000_0000;
  end
endmodule

// File: rtl/qn_doorbell_chk.sv
module qn_doorbell_chk
  import qn_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_QUEUES = 8,
  parameter int QIDX_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [15:0]       cfg_base,
  input logic [15:0]       cfg_mult,
  input logic              msi_enable,
  input logic              evt_used,
  input logic              notify_valid,
  input logic [QIDX_W-1:0] notify_queue,
  input logic              irq,
  input logic [31:0]       dev_status,
  input logic              dec_hit,
  input logic [1:0]        int_cause
);
  logic [31:0] a32;
  logic        mapped;
  assign a32    = 32'(bus_addr);
  assign mapped = (a32 == OFF_LAYOUT) || (a32 == OFF_CAUSE) || (a32 == OFF_ACK) ||
                  (a32 == OFF_DEVSTAT) || (a32 == OFF_MSICAP);

  assert_layout_read_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && a32 == OFF_LAYOUT) |=> bus_rdata == {$past(cfg_mult), $past(cfg_base)});

  assert_pulse_from_write_R2: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> $past(bus_wr));

  assert_queue_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> (32'(notify_queue) < 32'(NUM_QUEUES)));

  assert_used_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (evt_used && !msi_enable) |=> int_cause[0]);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !dec_hit && a32 == OFF_ACK && bus_wdata[0] && !(evt_used && !msi_enable))
      |=> !int_cause[0]);

  assert_msi_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    msi_enable |=> !irq);

  assert_doorbell_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec_hit) |=> $stable(dev_status));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> bus_rdata == 32'h0);
endmodule

bind qn_doorbell_regs qn_doorbell_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_QUEUES(NUM_QUEUES),
  .QIDX_W    (QIDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .cfg_base    (cfg_base),
  .cfg_mult    (cfg_mult),
  .msi_enable  (msi_enable),
  .evt_used    (evt_used),
  .notify_valid(notify_valid),
  .notify_queue(notify_queue),
  .irq         (irq),
  .dev_status  (dev_status),
  .dec_hit     (dec_hit),
  .int_cause   (int_cause)
);

// File: tb/tb_qn_doorbell_regs.sv
`timescale 1ns/1ps
module tb_qn_doorbell_regs;
  localparam int NQ = 8;
  localparam int QW = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] cfg_base = 16'h0050, cfg_mult = 16'h0000;
  logic        msi_enable = 1'b0, evt_used = 1'b0, evt_cfg = 1'b0;
  logic        notify_valid, irq;
  logic [QW-1:0] notify_queue;
  logic [31:0] dev_status;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [1:0]  m_cause = '0;
  logic [31:0] m_dev = '0;

  qn_doorbell_regs #(.ADDR_W(12), .NUM_QUEUES(NQ), .QIDX_W(QW)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_base(cfg_base),
    .cfg_mult(cfg_mult), .msi_enable(msi_enable), .evt_used(evt_used),
    .evt_cfg(evt_cfg), .notify_valid(notify_valid), .notify_queue(notify_queue),
    .irq(irq), .dev_status(dev_status));

  always #4 clk = ~clk;  // 125 MHz

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // doorbell expectation from R2/R3/R4, by offset arithmetic
  function automatic void exp_notify(input logic wr, input logic [11:0] a, input logic [31:0] d,
                                     output logic hit, output int q);
    hit = 1'b0; q = 0;
    if (wr) begin
      if (cfg_mult == 16'h0) begin
        if (int'(a) == int'(cfg_base) && d < 32'(NQ)) begin hit = 1'b1; q = int'(d); end
      end else if (int'(a) >= int'(cfg_base)) begin
        int off;
        off = int'(a) - int'(cfg_base);
        if (off % int'(cfg_mult) == 0 && off / int'(cfg_mult) < NQ) begin
          hit = 1'b1; q = off / int'(cfg_mult);
        end
      end
    end
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h050: return {cfg_mult, cfg_base};
      12'h060: return {30'h0, m_cause};
      12'h070: return m_dev;
      12'h0C0: return {15'h0, msi_enable, 16'(NQ)};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [11:0] a);
    case (a)
      12'h050: return "R1";
      12'h060: return "R5_R6";
      12'h070: return "R9";
      12'h0C0: return "R8";
      default: return "R11";
    endcase
  endfunction

  // one bus cycle: drive at negedge, predict, check at the next negedge
  task automatic step(input logic wr, input logic rd, input logic [11:0] a,
                      input logic [31:0] d, input logic eu, input logic ec);
    logic hit; int q; logic [31:0] rexp; logic [1:0] clr; logic iexp;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_used = eu; evt_cfg = ec;
    exp_notify(wr, a, d, hit, q);
    rexp = rd ? exp_read(a) : 32'h0;
    clr  = (wr && !hit && a == 12'h064) ? d[1:0] : 2'b00;
    m_cause = (m_cause & ~clr) | (msi_enable ? 2'b00 : {ec, eu});
    iexp = (|m_cause) && !msi_enable;
    if (wr && !hit && a == 12'h070) m_dev = d;
    @(posedge clk);
    @(negedge clk);
    check(cfg_mult == 0 ? "R3 notify_valid" : (hit ? "R2 notify_valid" : "R4 notify_valid"),
          32'(notify_valid), 32'(hit));
    if (hit) check(cfg_mult == 0 ? "R3 notify_queue" : "R2 notify_queue",
                   32'(notify_queue), 32'(q));
    check("R7 irq", 32'(irq), 32'(iexp));
    check("R9_R10 dev_status", dev_status, m_dev);
    check(rd ? rd_tag(a) : "R11 idle rdata", bus_rdata, rexp);
    bus_wr = 1'b0; bus_rd = 1'b0; evt_used = 1'b0; evt_cfg = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R12 reset state
    check("R12 notify_valid", 32'(notify_valid), 32'h0);
    check("R12 irq", 32'(irq), 32'h0);
    check("R12 rdata", bus_rdata, 32'h0);
    check("R12 dev_status", dev_status, 32'h0);
    step(0, 1, 12'h060, 0, 0, 0);

    // R3 shared address on the layout register itself
    cfg_base = 16'h0050; cfg_mult = 16'h0000;
    step(1, 0, 12'h050, 32'd3, 0, 0);
    step(1, 0, 12'h050, 32'd8, 0, 0);          // R4 index too large
    step(1, 0, 12'h050, 32'h0001_0003, 0, 0);  // R4 upper bits set
    step(1, 0, 12'h054, 32'd1, 0, 0);
    step(0, 1, 12'h050, 0, 0, 0);              // R1

    // R2 strided doorbells
    cfg_base = 16'h0100; cfg_mult = 16'h0004;
    step(1, 0, 12'h10C, 32'hDEAD, 0, 0);
    step(1, 0, 12'h11C, 32'h0, 0, 0);
    step(1, 0, 12'h10D, 32'h0, 0, 0);          // R4 off grid
    step(1, 0, 12'h120, 32'h0, 0, 0);          // R4 queue == NQ
    step(1, 0, 12'h0FC, 32'h0, 0, 0);          // R4 below base
    step(1, 1, 12'h100, 32'h0, 0, 0);
    step(0, 1, 12'h050, 0, 0, 0);

    // R5 R6 cause and acknowledge, same-cycle set vs clear
    step(0, 0, 12'h000, 0, 1, 0);
    step(0, 1, 12'h060, 0, 0, 1);
    step(1, 1, 12'h064, 32'h1, 1, 0);          // R6 event wins
    step(0, 1, 12'h060, 0, 0, 0);
    step(1, 0, 12'h064, 32'h2, 0, 0);
    step(1, 0, 12'h064, 32'hFFFF_FFFF, 0, 0);
    step(0, 1, 12'h060, 0, 0, 0);

    // R10 doorbell placed over fixed registers
    step(0, 0, 12'h000, 0, 0, 1);
    cfg_base = 16'h0064; cfg_mult = 16'h0000;
    step(1, 0, 12'h064, 32'd2, 0, 0);
    step(0, 1, 12'h060, 0, 0, 0);
    step(1, 0, 12'h070, 32'h1234_5678, 0, 0);
    cfg_base = 16'h0070;
    step(1, 0, 12'h070, 32'd1, 0, 0);
    step(0, 1, 12'h070, 0, 0, 0);

    // R7 R8 MSI on: events ignored, irq low
    msi_enable = 1'b1;
    step(0, 0, 12'h000, 0, 0, 0);
    step(0, 1, 12'h0C0, 0, 1, 1);
    step(1, 0, 12'h0C0, 32'hFFFF_FFFF, 0, 0);  // R11 read-only
    step(1, 0, 12'h060, 32'hFFFF_FFFF, 0, 0);
    step(1, 0, 12'h050, 32'hFFFF_FFFF, 0, 0);
    step(0, 1, 12'h0C0, 0, 0, 0);
    step(0, 1, 12'h060, 0, 0, 0);
    msi_enable = 1'b0;
    step(0, 1, 12'h044, 0, 0, 0);              // R11 unmapped
    step(0, 1, 12'h0C0, 0, 0, 0);

    // constrained random traffic
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a; logic [31:0] d; int q;
      if (i % 40 == 0) begin
        case ($urandom % 4)
          0: cfg_mult = 16'h0000;
          1: cfg_mult = 16'h0004;
          2: cfg_mult = 16'h0008;
          default: cfg_mult = 16'h0010;
        endcase
        if (cfg_mult == 0) begin
          case ($urandom % 4)
            0: cfg_base = 16'h0050;
            1: cfg_base = 16'h0064;
            2: cfg_base = 16'h0070;
            default: cfg_base = 16'h0200;
          endcase
        end else cfg_base = 16'h0040 + 16'(($urandom % 64) * 4);
        msi_enable = ($urandom % 4) == 0;
      end
      q = int'($urandom % (NQ + 1));
      d = $urandom;
      case ($urandom % 6)
        0: begin
             a = 12'(int'(cfg_base) + q * int'(cfg_mult));
             if (cfg_mult == 0) d = $urandom % (NQ + 2);
           end
        1: a = 12'(int'(cfg_base) + q * int'(cfg_mult) + 1 + int'($urandom % 2));
        2: a = 12'h064;
        3: a = 12'h070;
        4: a = ($urandom % 2) ? 12'h060 : 12'h0C0;
        default: a = 12'($urandom % 1024) & 12'hFFC;
      endcase
      step(($urandom % 4) != 0, ($urandom % 2) == 1, a, d,
           ($urandom % 4) == 0, ($urandom % 5) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule